// File: doc/BRIEF.md
# Board Clock Configuration Boot Sequencer

This block programs three serially configured clock devices right after power-up: the RF reference buffer, the sampling-clock buffer and the PLL that may sit on a plug-in clock module. A one-cycle start pulse captures two board descriptors. The first is a module-type code: no module, passive connector module, or PLL module. The second is a two-bit variant switch, A/B/C. From these two codes the block picks one register-write list per device and walks the lists in a fixed device order. Each list entry becomes one single-byte SPI write to the chip select of that device.

Every list is a pair of parallel columns, register addresses and data bytes, and it ends where the address column holds 0xFF. A list can be empty. In that case its device sees no traffic and the sequencer moves straight to the next device. The lists are computed into a registered on-chip ROM. Busy covers the whole walk, and a one-cycle done pulse marks its end.

Top module: `cfg_spi_boot`

## Requirements
- R1: Each write is a 24-bit SPI mode-0 frame sent MSB first, with the serial clock low while idle and MOSI sampled on the rising serial clock edge. The frame fields are: bit 23 = 0 (write), bits 22:21 = 00 (one byte), bits 20:8 = register address (upper five bits zero), bits 7:0 = data byte.
- R2: Devices are served in this order: RF reference buffer on `spi_cs_n[0]`, then sampling buffer on `spi_cs_n[1]`, then PLL on `spi_cs_n[2]`. At most one chip select is low at any time.
- R3: The walk through a list ends at the first entry whose address is 0xFF. That entry is never sent, and the entries before it are sent in list order.
- R4: `board_type` is decoded as 0 = no module, 1 = passive module, 2 = PLL module, and 3 is handled as no module. `variant` is decoded as 0 = A, 1 = B, and 2 or 3 = C. The variant has no effect when no module is present.
- R5: A device whose list is empty has its chip select held high for the whole run.
- R6: With no module, the PLL list is eight writes (address/data): 00/30, 00/10, 0A/11, 3D/03, 3E/03, 3F/03, 40/01, 41/01. It sends no commit. With a passive module, the PLL list is empty.
- R7: With a PLL module, variant B writes these 20 pairs in order: 00/30, 00/10, 04/02, 05/00, 06/03, 0B/00, 0C/01, 07/00, 08/47, 09/70, 0A/08, 3D/03, 3E/03, 3F/03, 40/02, 41/02, 51/80, 53/80, 45/02, 5A/01. Variant A instead writes 01 to 40. Variant C instead writes 40 to 0A.
- R8: The sampling buffer list is always 45/x, 51/80, 5A/01. x is 01 for no module and for passive variant A. x is 00 for every other passive variant and for every PLL-module variant.
- R9: The RF reference list is 45/01, 4A/33, 4B/00, 3D/08, 5A/01 only for PLL-module variant A, and empty otherwise.
- R10: The serial clock period is CLK_DIV system clocks. Between consecutive writes, all chip selects stay high for at least 2*CLK_DIV system clocks.
- R11: A start pulse seen while idle latches both descriptors. A start pulse seen while busy is ignored and changes neither the running lists nor the run.
- R12: After reset, and whenever idle, all chip selects are high and busy is low. Busy rises the cycle after an accepted start. When the last list ends, busy falls and done is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the boot sequence |
| board_type | input | 2 | Clock-module type code |
| variant | input | 2 | Module variant switch |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 3 | Active-low chip selects, one per device |

## Verification
The end of one run and the acceptance of the next can land in the same cycle. A start held high during the cycle in which done is high must begin a new run. The bench provokes this by raising start at the very sample where it sees done. It then expects busy in the following cycle and the new run's frame lists from the new descriptors. The opposite collision is a start pulse in the middle of a run. That pulse must fall into the ignore path, so the bench gives it different descriptors and judges that the frames still match the originally latched lists.

// File: rtl/cfg_spi_boot_pkg.sv
package cfg_spi_boot_pkg;

  localparam int NUM_DEV = 3;
  localparam int DEV_W   = $clog2(NUM_DEV);
  localparam int FRAME_W = 24;
  localparam logic [7:0] END_MARK = 8'hFF;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } wr_t;

  typedef enum logic [1:0] {W_IDLE, W_READ, W_EVAL, W_SEND} walk_st_t;

  function automatic logic [FRAME_W-1:0] make_frame(input wr_t e);
    return {1'b0, 2'b00, 5'b00000, e.addr, e.data};
  endfunction

  // Computed list content: dev 0 = RF ref, 1 = sampling, 2 = PLL
  function automatic wr_t list_entry(input logic [1:0] dev, input logic [1:0] brd,
                                     input logic [1:0] vsel, input int idx);
    wr_t e;
    logic pll, pas;
    int   v;
    e   = '{addr: END_MARK, data: 8'h00};
    pll = (brd == 2'd2);
    pas = (brd == 2'd1);
    v   = (vsel == 2'd3) ? 2 : int'(vsel);
    case (dev)
      2'd0: if (pll && v == 0) begin
        case (idx)
          0: e = '{8'h45, 8'h01};
          1: e = '{8'h4A, 8'h33};
          2: e = '{8'h4B, 8'h00};
          3: e = '{8'h3D, 8'h08};
          4: e = '{8'h5A, 8'h01};
          default: ;
        endcase
      end
      2'd1: begin
        case (idx)
          0: e = '{8'h45, ((!pll && !pas) || (pas && v == 0)) ? 8'h01 : 8'h00};
          1: e = '{8'h51, 8'h80};
          2: e = '{8'h5A, 8'h01};
          default: ;
        endcase
      end
      2'd2: if (pll) begin
        case (idx)
          0:  e = '{8'h00, 8'h30};
          1:  e = '{8'h00, 8'h10};
          2:  e = '{8'h04, 8'h02};
          3:  e = '{8'h05, 8'h00};
          4:  e = '{8'h06, 8'h03};
          5:  e = '{8'h0B, 8'h00};
          6:  e = '{8'h0C, 8'h01};
          7:  e = '{8'h07, 8'h00};
          8:  e = '{8'h08, 8'h47};
          9:  e = '{8'h09, 8'h70};
          10: e = '{8'h0A, (v == 2) ? 8'h40 : 8'h08};
          11: e = '{8'h3D, 8'h03};
          12: e = '{8'h3E, 8'h03};
          13: e = '{8'h3F, 8'h03};
          14: e = '{8'h40, (v == 0) ? 8'h01 : 8'h02};
          15: e = '{8'h41, 8'h02};
          16: e = '{8'h51, 8'h80};
          17: e = '{8'h53, 8'h80};
          18: e = '{8'h45, 8'h02};
          19: e = '{8'h5A, 8'h01};
          default: ;
        endcase
      end else if (!pas) begin
        case (idx)
          0: e = '{8'h00, 8'h30};
          1: e = '{8'h00, 8'h10};
          2: e = '{8'h0A, 8'h11};
          3: e = '{8'h3D, 8'h03};
          4: e = '{8'h3E, 8'h03};
          5: e = '{8'h3F, 8'h03};
          6: e = '{8'h40, 8'h01};
          7: e = '{8'h41, 8'h01};
          default: ;
        endcase
      end
      default: ;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/cfg_list_rom.sv
module cfg_list_rom
  import cfg_spi_boot_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic [DEV_W-1:0] dev,
  input  logic [1:0]       brd,
  input  logic [1:0]       vsel,
  input  logic [IDX_W-1:0] idx,
  output wr_t              entry
);

  always_ff @(posedge clk) begin
    entry <= list_entry(dev, brd, vsel, int'(idx));
  end

endmodule

// File: rtl/spi_wr_tx.sv
module spi_wr_tx #(
  parameter int CLK_DIV = 4,
  parameter int NUM_CS  = 3,
  parameter int FRAME_W = 24,
  localparam int HALF   = CLK_DIV / 2,
  localparam int GAP    = 2 * CLK_DIV,
  localparam int CNT_W  = $clog2(GAP + 1),
  localparam int BIT_W  = $clog2(FRAME_W),
  localparam int SEL_W  = $clog2(NUM_CS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [SEL_W-1:0]   sel,
  output logic               done,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_CS-1:0]  cs_n
);

  typedef enum logic [1:0] {T_IDLE, T_SHIFT, T_GAP} tx_st_t;

  tx_st_t             st;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bitn;

  assign mosi = shreg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= T_IDLE;
      shreg <= '0;
      cnt   <= '0;
      bitn  <= '0;
      sclk  <= 1'b0;
      done  <= 1'b0;
      cs_n  <= '1;
    end else begin
      done <= 1'b0;
      case (st)
        T_IDLE: if (start) begin
          shreg <= frame;
          cnt   <= '0;
          bitn  <= '0;
          sclk  <= 1'b0;
          for (int i = 0; i < NUM_CS; i++) cs_n[i] <= (SEL_W'(i) != sel);
          st    <= T_SHIFT;
        end
        T_SHIFT: begin
          if (cnt == CNT_W'(HALF - 1)) begin
            cnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bitn == BIT_W'(FRAME_W - 1)) begin
                cs_n  <= '1;
                shreg <= '0;
                st    <= T_GAP;
              end else begin
                shreg <= {shreg[FRAME_W-2:0], 1'b0};
                bitn  <= bitn + 1'b1;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        T_GAP: begin
          if (cnt == CNT_W'(GAP - 1)) begin
            cnt  <= '0;
            done <= 1'b1;
            st   <= T_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_walker.sv
module cfg_walker
  import cfg_spi_boot_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [1:0]         board_in,
  input  logic [1:0]         var_in,
  input  wr_t                entry,
  input  logic               tx_done,
  output logic [DEV_W-1:0]   dev,
  output logic [IDX_W-1:0]   idx,
  output logic [1:0]         brd,
  output logic [1:0]         vsel,
  output logic               tx_start,
  output logic [FRAME_W-1:0] frame,
  output logic               busy,
  output logic               done
);

  walk_st_t st;
  logic     list_end;

  assign list_end = (entry.addr == END_MARK) || (&idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= W_IDLE;
      dev      <= '0;
      idx      <= '0;
      brd      <= '0;
      vsel     <= '0;
      tx_start <= 1'b0;
      frame    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      done     <= 1'b0;
      case (st)
        W_IDLE: if (start) begin
          brd  <= board_in;
          vsel <= var_in;
          dev  <= '0;
          idx  <= '0;
          busy <= 1'b1;
          st   <= W_READ;
        end
        W_READ: st <= W_EVAL;
        W_EVAL: begin
          if (list_end) begin
            if (dev == DEV_W'(NUM_DEV - 1)) begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= W_IDLE;
            end else begin
              dev <= dev + 1'b1;
              idx <= '0;
              st  <= W_READ;
            end
          end else begin
            frame    <= make_frame(entry);
            tx_start <= 1'b1;
            st       <= W_SEND;
          end
        end
        W_SEND: if (tx_done) begin
          idx <= idx + 1'b1;
          st  <= W_READ;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_spi_boot.sv
module cfg_spi_boot
  import cfg_spi_boot_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [1:0]         board_type,
  input  logic [1:0]         variant,
  output logic               busy,
  output logic               done,
  output logic               spi_sclk,
  output logic               spi_mosi,
  output logic [NUM_DEV-1:0] spi_cs_n
);

  wr_t                entry;
  logic [DEV_W-1:0]   dev;
  logic [IDX_W-1:0]   idx;
  logic [1:0]         brd;
  logic [1:0]         vsel;
  logic               tx_start;
  logic               tx_done;
  logic [FRAME_W-1:0] frame;

  cfg_list_rom #(.IDX_W(IDX_W)) u_rom (
    .clk   (clk),
    .dev   (dev),
    .brd   (brd),
    .vsel  (vsel),
    .idx   (idx),
    .entry (entry)
  );

  cfg_walker #(.IDX_W(IDX_W)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .board_in (board_type),
    .var_in   (variant),
    .entry    (entry),
    .tx_done  (tx_done),
    .dev      (dev),
    .idx      (idx),
    .brd      (brd),
    .vsel     (vsel),
    .tx_start (tx_start),
    .frame    (frame),
    .busy     (busy),
    .done     (done)
  );

  spi_wr_tx #(.CLK_DIV(CLK_DIV), .NUM_CS(NUM_DEV), .FRAME_W(FRAME_W)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .start (tx_start),
    .frame (frame),
    .sel   (dev),
    .done  (tx_done),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .cs_n  (spi_cs_n)
  );

endmodule

// File: rtl/cfg_spi_boot_chk.sv
module cfg_spi_boot_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       spi_sclk,
  input logic [2:0] spi_cs_n
);

  // R2
  one_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~spi_cs_n) <= 1);

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (&spi_cs_n) |-> !spi_sclk);

  // R1
  cs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_cs_n) |-> !spi_sclk);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && (&spi_cs_n)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (&spi_cs_n));

  // R12
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  // R11
  start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

endmodule

bind cfg_spi_boot cfg_spi_boot_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .spi_sclk (spi_sclk),
  .spi_cs_n (spi_cs_n)
);

// File: tb/test_cfg_spi_boot.sv
module test_cfg_spi_boot;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] board_type = 2'd0;
  logic [1:0] variant = 2'd0;
  logic       busy, done, spi_sclk, spi_mosi;
  logic [2:0] spi_cs_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int exp_q[$];
  int exp_cnt[3];
  int got_cnt[3];
  int run_brd, run_var;

  logic [23:0] sh;
  int nbits, cur_dev, since_rise, gap_cnt, frames_run;
  logic prev_sclk;
  logic [2:0] prev_cs;
  logic mon_en = 1'b0;

  cfg_spi_boot #(.CLK_DIV(DIV)) i_cfg_spi_boot (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .board_type (board_type),
    .variant    (variant),
    .busy       (busy),
    .done       (done),
    .spi_sclk   (spi_sclk),
    .spi_mosi   (spi_mosi),
    .spi_cs_n   (spi_cs_n)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic string dev_tag(input int d);
    if (run_brd == 3 || (run_brd != 0 && run_var == 3)) return "R4";
    if (d == 0) return "R9";
    if (d == 1) return "R8";
    return (run_brd == 2) ? "R7" : "R6";
  endfunction

  task automatic push(input int d, input int a, input int v);
    exp_q.push_back((d << 16) | (a << 8) | v);
    exp_cnt[d]++;
  endtask

  // Expected lists, built from the requirements
  task automatic build_exp(input int b, input int v);
    bit no_mod, pas, pll;
    int vv;
    int pa[20];
    int pd[20];
    exp_q.delete();
    for (int i = 0; i < 3; i++) begin exp_cnt[i] = 0; got_cnt[i] = 0; end
    run_brd = b; run_var = v;
    no_mod = (b == 0 || b == 3);
    pas = (b == 1);
    pll = (b == 2);
    vv = (v == 3) ? 2 : v;
    if (pll && vv == 0) begin
      push(0, 'h45, 'h01); push(0, 'h4A, 'h33); push(0, 'h4B, 'h00);
      push(0, 'h3D, 'h08); push(0, 'h5A, 'h01);
    end
    push(1, 'h45, (no_mod || (pas && vv == 0)) ? 'h01 : 'h00);
    push(1, 'h51, 'h80);
    push(1, 'h5A, 'h01);
    if (pll) begin
      pa = '{'h00,'h00,'h04,'h05,'h06,'h0B,'h0C,'h07,'h08,'h09,
             'h0A,'h3D,'h3E,'h3F,'h40,'h41,'h51,'h53,'h45,'h5A};
      pd = '{'h30,'h10,'h02,'h00,'h03,'h00,'h01,'h00,'h47,'h70,
             'h08,'h03,'h03,'h03,'h02,'h02,'h80,'h80,'h02,'h01};
      if (vv == 0) pd[14] = 'h01;
      if (vv == 2) pd[10] = 'h40;
      for (int i = 0; i < 20; i++) push(2, pa[i], pd[i]);
    end else if (no_mod) begin
      push(2, 'h00, 'h30); push(2, 'h00, 'h10); push(2, 'h0A, 'h11);
      push(2, 'h3D, 'h03); push(2, 'h3E, 'h03); push(2, 'h3F, 'h03);
      push(2, 'h40, 'h01); push(2, 'h41, 'h01);
    end
  endtask

  // Watchdog
  always @(negedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      chk(1'b0, "watchdog", cycles, 190000);
      summary();
    end
  end

  // SPI capture monitor and per-clock comparison
  always @(negedge clk) begin
    if (rst || !mon_en) begin
      prev_sclk = 1'b0; prev_cs = 3'b111; nbits = 0; since_rise = 0;
      gap_cnt = 0; cur_dev = 0; sh = '0;
    end else begin
      chk($countones(~spi_cs_n) <= 1, "R2 one chip select", int'(spi_cs_n), 0);
      if (&spi_cs_n) chk(!spi_sclk, "R1 sclk idle low", int'(spi_sclk), 0);
      if (!busy) chk(&spi_cs_n, "R12 idle quiet", int'(spi_cs_n), 7);
      since_rise++;
      if (!(&prev_cs) && (&spi_cs_n)) begin
        int e;
        int a;
        chk(nbits == 24, "R1 frame length", nbits, 24);
        got_cnt[cur_dev]++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected frame", int'(sh), 0);
        end else begin
          e = exp_q.pop_front();
          a = (cur_dev << 16) | int'(sh[15:0]);
          chk(sh[23:16] == 8'h00, "R1 command bits", int'(sh[23:16]), 0);
          chk(a == e, dev_tag(e >> 16), a, e);
        end
        frames_run++;
        gap_cnt = 0;
      end
      if ((&prev_cs) && !(&spi_cs_n)) begin
        cur_dev = (!spi_cs_n[0]) ? 0 : (!spi_cs_n[1]) ? 1 : 2;
        if (frames_run > 0)
          chk(gap_cnt >= 2 * DIV, "R10 chip-select gap", gap_cnt, 2 * DIV);
        nbits = 0;
        sh = '0;
      end
      if (spi_sclk && !prev_sclk && !(&spi_cs_n)) begin
        if (nbits > 0) chk(since_rise == DIV, "R10 sclk period", since_rise, DIV);
        since_rise = 0;
        sh = {sh[22:0], spi_mosi};
        nbits++;
      end
      if (&spi_cs_n) gap_cnt++;
      prev_sclk = spi_sclk;
      prev_cs = spi_cs_n;
    end
  end

  task automatic issue_start(input int b, input int v);
    board_type = 2'(b);
    variant = 2'(v);
    build_exp(b, v);
    frames_run = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R12 busy after start", int'(busy), 1);
  endtask

  // Wait for done; optionally inject a start while busy
  task automatic wait_done(input bit inject);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (inject && n == 300) begin
        chk(busy, "R11 busy at injection", int'(busy), 1);
        board_type = 2'd0; variant = 2'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        board_type = 2'(run_brd); variant = 2'(run_var);
        n++;
      end
    end
    chk(done, "R12 done seen", int'(done), 1);
    chk(!busy, "R12 busy low at done", int'(busy), 0);
    chk(&spi_cs_n, "R12 cs high at done", int'(spi_cs_n), 7);
    chk(exp_q.size() == 0, "R3 all entries sent", exp_q.size(), 0);
    for (int d = 0; d < 3; d++) begin
      if (exp_cnt[d] == 0)
        chk(got_cnt[d] == 0, "R5 empty list silent", got_cnt[d], 0);
      else
        chk(got_cnt[d] == exp_cnt[d], "R3 write count", got_cnt[d], exp_cnt[d]);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(spi_cs_n == 3'b111, "R12 reset cs", int'(spi_cs_n), 7);
    chk(!busy, "R12 reset busy", int'(busy), 0);
    chk(!done, "R12 reset done", int'(done), 0);
    chk(!spi_sclk, "R12 reset sclk", int'(spi_sclk), 0);
    mon_en = 1'b1;
    @(negedge clk);

    // Standalone runs
    issue_start(0, 0); wait_done(1'b0);
    @(negedge clk);
    chk(!done, "R12 done one cycle", int'(done), 0);
    repeat (20) @(negedge clk);
    chk(spi_cs_n == 3'b111, "R12 quiet after done", int'(spi_cs_n), 7);

    issue_start(2, 1); wait_done(1'b1);   // R11 mid-run start ignored
    @(negedge clk);

    // Back-to-back: start raised in the done cycle (R11, R12)
    issue_start(2, 0); wait_done(1'b0);
    issue_start(2, 2); wait_done(1'b0);
    issue_start(1, 0); wait_done(1'b0);
    issue_start(1, 1); wait_done(1'b0);
    issue_start(1, 2); wait_done(1'b0);
    issue_start(0, 2); wait_done(1'b0);
    issue_start(3, 1); wait_done(1'b0);
    issue_start(2, 3); wait_done(1'b0);
    issue_start(1, 3); wait_done(1'b1);
    @(negedge clk);
    chk(!busy && !done, "R12 final idle", int'({busy, done}), 0);
    summary();
  end

endmodule